// File: doc/BRIEF.md
# B3ZS/HDB3 Line Decoder with Violation Classification

This block turns a stream of retimed bipolar line symbols into NRZ data. Each symbol arrives as two rail flags, one for a positive pulse and one for a negative pulse. It then emits one data bit and one violation bit per symbol. A static mode input selects three-zero substitution (B3ZS) or four-zero substitution (HDB3). The block finds valid zero-substitution patterns and removes them. It sorts every other irregularity into one of four classes: excessive zeros, bipolar violation, coding violation and a double-rail symbol. Each class has a fixed output data value. The violation bit rides in the same output slot as the data bit it marks.

Symbols pass through a four-entry delay line. This lets the block clear the leading pulse of a substitution before that pulse leaves. A bypass input outputs the raw rails in place of the decoded pair.

Both edges are valid/ready streams. An input symbol is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low only while an output is pending (`out_valid` high) and `out_ready` is low. While stalled like this, the output pair holds steady. The pipeline advances only when a symbol is accepted. So a symbol's result appears on the edge that accepts the fourth symbol after it, and a stream's last four symbols stay inside until more symbols push them out.

Top module: `lcd_decoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. The decoder state starts as: last pulse negative, pulse parity even, zero-run count 0. The delay line holds zero symbols.
- R2: A symbol is accepted when `in_valid` and `in_ready` are both high. `in_ready` is low only while `out_valid`=1 and `out_ready`=0, and during such a stall `out_valid`, `out_data` and `out_viol` hold. Each accepted symbol is presented on `out_data`/`out_viol` right after the edge that accepts the fourth symbol following it. Nothing is presented before that.
- R3: Rail encoding: `in_pos`=1,`in_neg`=0 is a positive pulse; `in_pos`=0,`in_neg`=1 is a negative pulse; both 0 is a zero. A single-rail pulse whose polarity is opposite to the previous single-rail pulse is normal. It outputs data 1, violation 0, and toggles the pulse parity.
- R4: With `bypass`=1 at the moment a symbol is presented, `out_data` equals that symbol's `in_pos` and `out_viol` equals its `in_neg`.
- R5: A zero symbol adds one to the zero-run count, and any pulse clears the count. The zero that brings the run to 4 (HDB3) or 3 (B3ZS) outputs data 0 with violation 1, and the count restarts at 0.
- R6: Some single-rail pulses have the same polarity as the previous single-rail pulse. If such a pulse is not preceded by the substitution gap, it is a bipolar violation. The gap is the previous symbol being zero (B3ZS), or the previous two symbols being zero (HDB3). A bipolar violation outputs data 1, violation 1 and toggles the parity.
- R7: A same-polarity pulse that follows the substitution gap while the parity is odd is a valid substitution. It outputs data 0, violation 0 and clears the parity to even. The symbol just before the gap is 2 back in B3ZS and 3 back in HDB3. If that symbol is an unflagged single-rail pulse, its data is also output as 0.
- R8: A same-polarity pulse that follows the substitution gap while the parity is even is a coding violation. It outputs data 0, violation 1 and clears the parity to even.
- R9: A symbol with both rails high outputs data 1, violation 1 and toggles the parity. It does not change the remembered last polarity.
- R10: `mode_hdb3`=1 selects HDB3 and 0 selects B3ZS. It is changed only while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_hdb3 | input | 1 | 1 = HDB3, 0 = B3ZS |
| bypass | input | 1 | 1 = present raw rails instead of decoded pair |
| in_valid | input | 1 | Input symbol valid |
| in_ready | output | 1 | Block can accept a symbol |
| in_pos | input | 1 | Positive-pulse rail |
| in_neg | input | 1 | Negative-pulse rail |
| out_valid | output | 1 | Output pair valid |
| out_ready | input | 1 | Downstream accepts the output pair |
| out_data | output | 1 | Decoded NRZ bit (raw positive rail in bypass) |
| out_viol | output | 1 | Violation flag (raw negative rail in bypass) |

## Verification
The assertions check several things on every cycle. Output holds during a stall, and output validity only rises after an accepted symbol. The zero-run count stays below the mode's limit. Excessive-zero, valid-substitution and double-rail classifications land correctly in the delay line, and the bypass path presents the raw rails. Other behaviour depends on whole symbol sequences, and only the bench's scenarios can show it. This covers the parity history that separates a valid substitution from a coding violation, the retroactive clearing of the leading pulse, the four-symbol latency and the behaviour under mixed input and output stalls.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

  typedef enum logic [2:0] {
    C_ZERO    = 3'd0,
    C_EXCESS  = 3'd1,
    C_NORMAL  = 3'd2,
    C_BIPOLAR = 3'd3,
    C_SUB     = 3'd4,
    C_CODING  = 3'd5,
    C_DOUBLE  = 3'd6
  } cls_t;

  typedef struct packed {
    logic pos;
    logic neg;
    logic dat;
    logic flg;
    logic vld;
  } slot_t;

endpackage

// File: rtl/lcd_classify.sv
module lcd_classify
  import lcd_pkg::*;
#(
  parameter int HDB3_RUN = 4,
  parameter int B3ZS_RUN = 3,
  parameter int ZW       = 3,
  localparam int GAP_MAX = HDB3_RUN - 2
) (
  input  logic               mode_hdb3,
  input  logic               pos,
  input  logic               neg,
  input  logic [GAP_MAX-1:0] prev_pul,
  input  logic               last_pol,
  input  logic               parity,
  input  logic [ZW-1:0]      zrun,
  output cls_t               cls,
  output logic               dat,
  output logic               flg
);

  logic          shape;
  logic [ZW-1:0] run_lim;
  int            gap;

  always_comb begin
    gap     = mode_hdb3 ? (HDB3_RUN - 2) : (B3ZS_RUN - 2);
    run_lim = mode_hdb3 ? ZW'(HDB3_RUN) : ZW'(B3ZS_RUN);
    shape   = 1'b1;
    for (int j = 0; j < GAP_MAX; j++) begin
      if (j < gap && prev_pul[j]) shape = 1'b0;
    end
  end

  always_comb begin
    if (pos && neg) begin
      cls = C_DOUBLE;
    end else if (pos || neg) begin
      if (pos != last_pol) cls = C_NORMAL;
      else if (!shape)     cls = C_BIPOLAR;
      else if (parity)     cls = C_SUB;
      else                 cls = C_CODING;
    end else begin
      cls = (zrun + ZW'(1) == run_lim) ? C_EXCESS : C_ZERO;
    end
  end

  always_comb begin
    dat = (cls == C_NORMAL) || (cls == C_BIPOLAR) || (cls == C_DOUBLE);
    flg = (cls == C_EXCESS) || (cls == C_BIPOLAR) ||
          (cls == C_CODING) || (cls == C_DOUBLE);
  end

endmodule

// File: rtl/lcd_track.sv
module lcd_track
  import lcd_pkg::*;
#(
  parameter int HDB3_RUN = 4,
  parameter int B3ZS_RUN = 3,
  parameter int ZW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_hdb3,
  input  logic          adv,
  input  cls_t          cls,
  input  logic          pos,
  output logic          last_pol,
  output logic          parity,
  output logic [ZW-1:0] zrun
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_pol <= 1'b0;
      parity   <= 1'b0;
      zrun     <= '0;
    end else if (adv) begin
      unique case (cls)
        C_ZERO:   zrun <= zrun + ZW'(1);
        C_EXCESS: zrun <= '0;
        C_NORMAL: begin
          last_pol <= pos;
          parity   <= ~parity;
          zrun     <= '0;
        end
        C_BIPOLAR, C_DOUBLE: begin
          parity <= ~parity;
          zrun   <= '0;
        end
        default: begin
          parity <= 1'b0;
          zrun   <= '0;
        end
      endcase
    end
  end

  // R5: the run count never reaches the mode's limit
  p_zrun_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    zrun < (mode_hdb3 ? ZW'(HDB3_RUN) : ZW'(B3ZS_RUN)));

endmodule

// File: rtl/lcd_decoder.sv
module lcd_decoder
  import lcd_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int HDB3_RUN = 4,
  parameter int B3ZS_RUN = 3,
  localparam int ZW      = $clog2(HDB3_RUN + 1),
  localparam int GAP_MAX = HDB3_RUN - 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_hdb3,
  input  logic bypass,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_pos,
  input  logic in_neg,
  output logic out_valid,
  input  logic out_ready,
  output logic out_data,
  output logic out_viol
);

  slot_t               line    [DEPTH];
  slot_t               line_nx [DEPTH];
  logic [DEPTH-1:0]    clr;
  logic [GAP_MAX-1:0]  prev_pul;
  logic                adv;
  cls_t                cls;
  logic                cls_dat;
  logic                cls_flg;
  logic                last_pol;
  logic                parity;
  logic [ZW-1:0]       zrun;
  int                  pre_idx;

  assign in_ready = !out_valid || out_ready;
  assign adv      = in_valid && in_ready;
  assign pre_idx  = mode_hdb3 ? (HDB3_RUN - 2) : (B3ZS_RUN - 2);

  for (genvar j = 0; j < GAP_MAX; j++) begin : g_prev
    assign prev_pul[j] = line[j].pos | line[j].neg;
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_clr
    assign clr[k] = (cls == C_SUB) && (k == pre_idx) &&
                    (line[k].pos ^ line[k].neg) && !line[k].flg;
  end

  lcd_classify #(.HDB3_RUN(HDB3_RUN), .B3ZS_RUN(B3ZS_RUN), .ZW(ZW)) u_cls (
    .mode_hdb3 (mode_hdb3),
    .pos       (in_pos),
    .neg       (in_neg),
    .prev_pul  (prev_pul),
    .last_pol  (last_pol),
    .parity    (parity),
    .zrun      (zrun),
    .cls       (cls),
    .dat       (cls_dat),
    .flg       (cls_flg)
  );

  lcd_track #(.HDB3_RUN(HDB3_RUN), .B3ZS_RUN(B3ZS_RUN), .ZW(ZW)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_hdb3 (mode_hdb3),
    .adv       (adv),
    .cls       (cls),
    .pos       (in_pos),
    .last_pol  (last_pol),
    .parity    (parity),
    .zrun      (zrun)
  );

  always_comb begin
    line_nx[0] = '{pos: in_pos, neg: in_neg, dat: cls_dat, flg: cls_flg, vld: 1'b1};
    for (int k = 1; k < DEPTH; k++) begin
      line_nx[k]     = line[k-1];
      line_nx[k].dat = line[k-1].dat & ~clr[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) line[k] <= '0;
      out_valid <= 1'b0;
      out_data  <= 1'b0;
      out_viol  <= 1'b0;
    end else if (adv) begin
      for (int k = 0; k < DEPTH; k++) line[k] <= line_nx[k];
      out_valid <= line[DEPTH-1].vld;
      out_data  <= bypass ? line[DEPTH-1].pos : line[DEPTH-1].dat;
      out_viol  <= bypass ? line[DEPTH-1].neg : line[DEPTH-1].flg;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R2: a stalled output pair holds
  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_viol)));

  // R2: output validity only appears after an accepted symbol
  p_rise_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  // R5: an excess-zero symbol is stored as flagged zero
  p_excess_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cls == C_EXCESS) |=> (line[0].flg && !line[0].dat));

  // R7: a valid substitution pulse is stored clean
  p_sub_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cls == C_SUB) |=> (!line[0].flg && !line[0].dat));

  // R9: both rails high stores a flagged one
  p_double_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && in_pos && in_neg) |=> (line[0].flg && line[0].dat));

  // R4: bypass presents the raw rails of the leaving symbol
  p_bypass_raw_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && bypass && line[DEPTH-1].vld) |=>
      (out_data == $past(line[DEPTH-1].pos) && out_viol == $past(line[DEPTH-1].neg)));

endmodule

// File: tb/test_lcd_decoder.sv
`timescale 1ns/1ps
module test_lcd_decoder;

  localparam logic [1:0] Z = 2'b00, P = 2'b10, N = 2'b01, D = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_hdb3 = 1'b1;
  logic bypass = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic in_pos = 1'b0;
  logic in_neg = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic out_data;
  logic out_viol;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  logic [1:0] seq [0:63];
  logic       exp_d [0:63];
  logic       exp_v [0:63];
  logic       got_d [0:63];
  logic       got_v [0:63];
  int n = 0;
  int got_n = 0;

  always #2 clk = ~clk;

  lcd_decoder i_lcd_decoder (
    .clk(clk), .rst_n(rst_n), .mode_hdb3(mode_hdb3), .bypass(bypass),
    .in_valid(in_valid), .in_ready(in_ready), .in_pos(in_pos), .in_neg(in_neg),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_viol(out_viol)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input bit hdb);
    @(negedge clk);
    rst_n = 1'b0;
    mode_hdb3 = hdb;
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic add(input logic [1:0] s);
    seq[n] = s;
    n++;
  endtask

  // Reference from the requirements: R3 R5 R6 R7 R8 R9
  task automatic model(input bit hdb);
    bit lastp = 1'b0;
    bit par = 1'b0;
    int zr = 0;
    int lim = hdb ? 4 : 3;
    int gap = hdb ? 2 : 1;
    for (int i = 0; i < n; i++) begin
      bit p = seq[i][1];
      bit q = seq[i][0];
      exp_d[i] = 1'b0;
      exp_v[i] = 1'b0;
      if (p && q) begin
        exp_d[i] = 1'b1; exp_v[i] = 1'b1; par = ~par; zr = 0;
      end else if (p || q) begin
        zr = 0;
        if (p != lastp) begin
          exp_d[i] = 1'b1; par = ~par; lastp = p;
        end else begin
          bit shp = 1'b1;
          for (int j = 1; j <= gap; j++)
            if (i - j >= 0 && seq[i-j] != Z) shp = 1'b0;
          if (!shp) begin
            exp_d[i] = 1'b1; exp_v[i] = 1'b1; par = ~par;
          end else if (par) begin
            int pr = i - gap - 1;
            if (pr >= 0 && (seq[pr] == P || seq[pr] == N) && !exp_v[pr]) exp_d[pr] = 1'b0;
            par = 1'b0;
          end else begin
            exp_v[i] = 1'b1; par = 1'b0;
          end
        end
      end else begin
        zr++;
        if (zr == lim) begin exp_v[i] = 1'b1; zr = 0; end
      end
    end
  endtask

  task automatic run_seq(input string req, input bit hdb, input bit byp, input bit stall);
    int idx = 0;
    for (int k = 0; k < 4; k++) add(Z);
    model(hdb);
    do_reset(hdb);
    bypass = byp;
    got_n = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      out_ready = stall ? (c % 3 != 2) : 1'b1;
      in_valid = (idx < n) && (stall ? (c % 5 != 4) : 1'b1);
      {in_pos, in_neg} = (idx < n) ? seq[idx] : 2'b00;
      #1;
      if (out_valid && out_ready) begin
        got_d[got_n] = out_data;
        got_v[got_n] = out_viol;
        got_n++;
      end
      if (in_valid && in_ready) idx++;
    end
    in_valid = 1'b0;
    chk(got_n == n - 4, req, "output count", got_n, n - 4);
    for (int i = 0; i < got_n && i < n - 4; i++) begin
      logic ed = byp ? seq[i][1] : exp_d[i];
      logic ev = byp ? seq[i][0] : exp_v[i];
      chk(got_d[i] == ed, req, $sformatf("data sym %0d", i), int'(got_d[i]), int'(ed));
      chk(got_v[i] == ev, req, $sformatf("viol sym %0d", i), int'(got_v[i]), int'(ev));
    end
    n = 0;
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_latency();
    do_reset(1'b1);
    bypass = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      {in_pos, in_neg} = (k == 0) ? P : Z;
      #1;
      chk(out_valid == 1'b0, "R2", $sformatf("no output before symbol %0d", k), int'(out_valid), 0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(out_valid == 1'b1, "R2", "output after fifth symbol", int'(out_valid), 1);
    chk(out_data == 1'b1, "R2", "first symbol data", int'(out_data), 1);
  endtask

  task automatic t_stall_hold();
    do_reset(1'b1);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      {in_pos, in_neg} = (k == 0) ? P : Z;
    end
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1;
    {in_pos, in_neg} = N;
    #1;
    chk(in_ready == 1'b0, "R2", "in_ready low in stall", int'(in_ready), 0);
    @(negedge clk);
    #1;
    chk(out_valid == 1'b1 && out_data == 1'b1, "R2", "held output", int'(out_data), 1);
    out_ready = 1'b1;
    in_valid = 1'b0;
  endtask

  task automatic t_hdb3_subs();
    add(P); add(N); add(P); add(Z); add(Z); add(P);
    add(N); add(Z); add(Z); add(Z); add(N);
    add(P); add(N); add(Z); add(P);
    run_seq("R3/R7", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_hdb3_coding();
    add(P); add(N); add(Z); add(Z); add(N);
    add(P); add(Z); add(Z); add(Z); add(P);
    run_seq("R8", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_hdb3_excess();
    add(P);
    for (int k = 0; k < 9; k++) add(Z);
    add(N); add(Z); add(Z); add(Z); add(P);
    run_seq("R5", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_bipolar();
    add(P); add(P); add(N); add(Z); add(N); add(P); add(Z); add(P);
    run_seq("R6", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_b3zs();
    add(P); add(Z); add(P); add(N); add(Z); add(Z); add(N);
    add(P); add(N); add(Z); add(N); add(P); add(P);
    add(Z); add(Z); add(Z); add(Z); add(Z); add(Z); add(N);
    run_seq("R10/R5/R7/R8", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_double();
    add(P); add(D); add(N); add(D); add(Z); add(Z); add(N); add(P);
    run_seq("R9", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_bypass();
    add(P); add(N); add(D); add(Z); add(P); add(P); add(Z); add(N);
    run_seq("R4", 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_stream_stall();
    for (int k = 0; k < 30; k++) begin
      case (k % 7)
        0: add(P);
        1: add(Z);
        2: add(N);
        3: add(Z);
        4: add(Z);
        5: add(N);
        default: add((k % 2) ? P : Z);
      endcase
    end
    run_seq("R2", 1'b1, 1'b0, 1'b1);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_stall_hold();
    t_hdb3_subs();
    t_hdb3_coding();
    t_hdb3_excess();
    t_bipolar();
    t_b3zs();
    t_double();
    t_bypass();
    t_stream_stall();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule